// File: doc/BRIEF.md
# SMBus Bus-Condition Sequencer

This block places START, repeated START and STOP conditions on a two-wire open-drain bus on behalf of a master/slave serial controller. Software writes a small control word holding an enable, a start request, a stop request, a long-first-start option and an acknowledge-assert bit. The block watches the wired SDA and SCL levels to decide whether the bus is free. It then pulls the lines low in the right order, paced by a half-bit-period tick. That tick is an enable pulse at twice the baud rate, supplied by the clock generator.

A START on a free bus waits three half-ticks. The first START after the enable goes high waits twenty half-ticks when the long-first-start option is set. A start request is held off while another master owns the bus, and while the controller is being addressed as a slave. Once the block is master and at least one byte has moved, a start request produces a repeated START. A stop request is served before a start request, so asking for both yields STOP followed by a fresh START. The stop request bit clears itself when a STOP is seen on the bus. The start request bit is cleared only by software. An interrupt flag marks each completed START and STOP. Byte shifting and address matching live elsewhere; they reach this block as the `slv_addr` level and the `byte_done` pulse.

Top module: `smb_cond_seq`

## Requirements
- R1: After reset, and on the cycle after the enable bit (control bit 0) reads 0, both line drivers are off, `is_master` is 0 and `bus_busy` is 0. Any transfer in progress is abandoned.
- R2: With the bus free, a start request (control bit 1) asserts `sda_oe` in the cycle after the third half-tick counted from the cycle following the register update. `scl_oe` then asserts one half-tick after `sda_oe`.
- R3: On the first start after the enable bit rises, with the long-first-start bit (control bit 3) set, the delay is twenty half-ticks instead of three.
- R4: While `bus_busy` is 1 (a START from another master has been seen and no STOP yet), no START is driven. The pending request proceeds once a STOP frees the bus.
- R5: While `slv_addr` is 1, no START is driven. The request proceeds once `slv_addr` returns to 0 with the bus free.
- R6: As master, once `byte_done` has pulsed since the last START and the start request is set, the block releases SDA and then SCL and drives a repeated START. `is_master` stays 1 throughout.
- R7: As master, a stop request (control bit 2) releases SCL while SDA is held low, then releases SDA. Bit 2 clears when the resulting STOP is detected, and `is_master` drops at that point.
- R8: With start and stop requests both set while master, the STOP is completed before the next START is driven.
- R9: The control word reads back exactly as written, including the acknowledge-assert bit (control bit 4). The only exception is bit 2, which hardware clears. Bit 1 is never cleared by hardware.
- R10: `si` sets when a START completes (SCL pulled low after SDA) and when a STOP completes. It clears on `si_clr`, and a new event in the same cycle takes priority.
- R11: `bus_busy` sets on SDA falling while SCL is high and clears on SDA rising while SCL is high, as observed on `sda_in`/`scl_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word: bit0 enable, bit1 start req, bit2 stop req, bit3 long first start, bit4 ack assert |
| ctl_q | output | 5 | Control word readback |
| si_clr | input | 1 | Clears the interrupt flag |
| half_tick | input | 1 | Pulse at twice the baud rate |
| sda_in | input | 1 | Wired SDA level |
| scl_in | input | 1 | Wired SCL level |
| slv_addr | input | 1 | Controller is currently an addressed slave |
| byte_done | input | 1 | Pulse: a byte finished transferring |
| sda_oe | output | 1 | Pull SDA low |
| scl_oe | output | 1 | Pull SCL low |
| is_master | output | 1 | Block owns the bus |
| bus_busy | output | 1 | Bus held by some master |
| si | output | 1 | Serial event interrupt flag |

## Verification
The bench counts half-ticks for the short and the long start delay. A design that mixed them up, or that applied the long delay again after the first start, would assert SDA a multiple of four cycles off. The bench pulls SDA low externally to fake a foreign START and raises the slave-addressed level. A design that ignored either would drive a START over another transfer. A combined stop-and-start request is checked for a falling `is_master` before it rises again. A repeated START is checked for never dropping mastership. After the STOP, the stop bit must read as cleared while the start bit stays set.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;
   localparam int CTL_W   = 5;
   localparam int CTL_EN  = 0;
   localparam int CTL_STA = 1;
   localparam int CTL_STO = 2;
   localparam int CTL_DLY = 3;
   localparam int CTL_AA  = 4;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_WAIT   = 3'd1,
      ST_SDA_LO = 3'd2,
      ST_HELD   = 3'd3,
      ST_STOP_A = 3'd4,
      ST_STOP_B = 3'd5,
      ST_RSTA_A = 3'd6,
      ST_RSTA_B = 3'd7
   } seq_state_t;
endpackage

// File: rtl/smb_line_mon.sv
module smb_line_mon #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sda_in,
   input  logic scl_in,
   output logic start_det,
   output logic stop_det,
   output logic busy
);
   logic sda_s, scl_s, sda_q, scl_q;

   if (SYNC_STAGES < 0) begin : g_bad
      $error("SYNC_STAGES must not be negative");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign sda_s = sda_in;
      assign scl_s = scl_in;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sda_p, scl_p;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sda_p <= '1;
            scl_p <= '1;
         end else begin
            sda_p <= SYNC_STAGES'({sda_p, sda_in});
            scl_p <= SYNC_STAGES'({scl_p, scl_in});
         end
      end
      assign sda_s = sda_p[SYNC_STAGES-1];
      assign scl_s = scl_p[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_q <= 1'b1;
         scl_q <= 1'b1;
      end else begin
         sda_q <= sda_s;
         scl_q <= scl_s;
      end
   end

   assign start_det = sda_q & ~sda_s & scl_q & scl_s;
   assign stop_det  = ~sda_q & sda_s & scl_q & scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy <= 1'b0;
      else if (!en)       busy <= 1'b0;
      else if (start_det) busy <= 1'b1;
      else if (stop_det)  busy <= 1'b0;
   end
endmodule

// File: rtl/smb_half_tick_delay.sv
module smb_half_tick_delay #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             hold,
   output logic             expire
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (load)                cnt <= load_val;
      else if (!hold)               cnt <= '0;
      else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expire = hold && tick && (cnt == CNT_W'(1));
endmodule

// File: rtl/smb_cond_seq.sv
module smb_cond_seq
   import smb_seq_pkg::*;
#(
   parameter int SHORT_HT    = 3,
   parameter int LONG_HT     = 20,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_q,
   input  logic             si_clr,
   input  logic             half_tick,
   input  logic             sda_in,
   input  logic             scl_in,
   input  logic             slv_addr,
   input  logic             byte_done,
   output logic             sda_oe,
   output logic             scl_oe,
   output logic             is_master,
   output logic             bus_busy,
   output logic             si
);
   localparam int CNT_W = $clog2(LONG_HT + 1);

   if (SHORT_HT < 1 || LONG_HT < SHORT_HT) begin : g_bad_delay
      $error("delays need 1 <= SHORT_HT <= LONG_HT");
   end

   seq_state_t state;
   logic run, start_det, stop_det, expire, first_pend, bytes_seen;
   logic wait_abort, enter_first, enter_sda, load_wait;
   logic [CNT_W-1:0] load_val;

   assign run = ctl_q[CTL_EN];

   smb_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk(clk), .rst_n(rst_n), .en(run), .sda_in(sda_in), .scl_in(scl_in),
      .start_det(start_det), .stop_det(stop_det), .busy(bus_busy)
   );

   assign load_wait  = run && state == ST_IDLE && ctl_q[CTL_STA] && !slv_addr && !bus_busy;
   assign load_val   = (first_pend && ctl_q[CTL_DLY]) ? CNT_W'(LONG_HT) : CNT_W'(SHORT_HT);
   assign wait_abort = bus_busy || slv_addr || !ctl_q[CTL_STA];

   smb_half_tick_delay #(.CNT_W(CNT_W)) u_dly (
      .clk(clk), .rst_n(rst_n), .load(load_wait), .load_val(load_val),
      .tick(half_tick), .hold(state == ST_WAIT), .expire(expire)
   );

   assign enter_first = run && state == ST_WAIT && !wait_abort && expire;
   assign enter_sda   = enter_first || (run && state == ST_RSTA_B && half_tick);

   // control word: software write wins over the hardware stop clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ctl_q <= '0;
      else if (ctl_wr)   ctl_q <= ctl_wdata;
      else if (stop_det) ctl_q[CTL_STO] <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                         first_pend <= 1'b0;
      else if (ctl_wr && ctl_wdata[CTL_EN] && !run)       first_pend <= 1'b1;
      else if (enter_first)                               first_pend <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       bytes_seen <= 1'b0;
      else if (!run || enter_sda)       bytes_seen <= 1'b0;
      else if (byte_done && is_master)  bytes_seen <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         is_master <= 1'b0;
         si        <= 1'b0;
      end else if (!run) begin
         state     <= ST_IDLE;
         is_master <= 1'b0;
         if (si_clr) si <= 1'b0;
      end else begin
         if (si_clr) si <= 1'b0;
         case (state)
            ST_IDLE:   if (load_wait) state <= ST_WAIT;
            ST_WAIT:   if (wait_abort) state <= ST_IDLE;
                       else if (expire) state <= ST_SDA_LO;
            ST_SDA_LO: if (half_tick) begin
                          state     <= ST_HELD;
                          is_master <= 1'b1;
                          si        <= 1'b1;
                       end
            ST_HELD:   if (half_tick) begin
                          if (ctl_q[CTL_STO])                   state <= ST_STOP_A;
                          else if (ctl_q[CTL_STA] && bytes_seen) state <= ST_RSTA_A;
                       end
            ST_STOP_A: if (half_tick) state <= ST_STOP_B;
            ST_STOP_B: if (stop_det) begin
                          state     <= ST_IDLE;
                          is_master <= 1'b0;
                          si        <= 1'b1;
                       end
            ST_RSTA_A: if (half_tick) state <= ST_RSTA_B;
            ST_RSTA_B: if (half_tick) state <= ST_SDA_LO;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      sda_oe = 1'b0;
      scl_oe = 1'b0;
      case (state)
         ST_SDA_LO: sda_oe = 1'b1;
         ST_HELD:   begin sda_oe = 1'b1; scl_oe = 1'b1; end
         ST_STOP_A: sda_oe = 1'b1;
         ST_RSTA_A: scl_oe = 1'b1;
         default:   ;
      endcase
   end
endmodule

// File: rtl/smb_cond_seq_chk.sv
module smb_cond_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ctl_wr,
   input logic [4:0] ctl_q,
   input logic       sda_oe,
   input logic       scl_oe,
   input logic       is_master,
   input logic       si,
   input logic       slv_addr,
   input logic       stop_det
);
   assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[0] |=> (!sda_oe && !scl_oe && !is_master));

   assert_scl_after_sda_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_oe) |-> sda_oe);

   assert_no_start_as_slave_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe) && !is_master) |-> !$past(slv_addr));

   assert_sto_hw_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_q[2]) |-> ($past(ctl_wr) || $past(stop_det)));

   assert_sta_sw_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_q[1]) |-> $past(ctl_wr));

   assert_si_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(si) |-> ((is_master && sda_oe && scl_oe) || (!is_master && !sda_oe)));
endmodule

bind smb_cond_seq smb_cond_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_q(ctl_q), .sda_oe(sda_oe),
   .scl_oe(scl_oe), .is_master(is_master), .si(si), .slv_addr(slv_addr),
   .stop_det(stop_det)
);

// File: tb/smb_cond_seq_bench.sv
`timescale 1ns/1ps
module smb_cond_seq_bench;
   logic clk = 0, rst_n = 0;
   logic ctl_wr = 0, si_clr = 0, half_tick = 0, slv_addr = 0, byte_done = 0;
   logic ext_sda = 0, ext_scl = 0;
   logic [4:0] ctl_wdata = 0, ctl_q;
   logic sda_oe, scl_oe, is_master, bus_busy, si;
   wire  sda_line = !(sda_oe || ext_sda);
   wire  scl_line = !(scl_oe || ext_scl);
   int   errors = 0, checks = 0, tcnt = 0;
   string cur_req = "R1";
   bit   done = 0;

   always #4 clk = ~clk;

   smb_cond_seq u_smb_cond_seq (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
      .si_clr(si_clr), .half_tick(half_tick), .sda_in(sda_line), .scl_in(scl_line),
      .slv_addr(slv_addr), .byte_done(byte_done), .sda_oe(sda_oe), .scl_oe(scl_oe),
      .is_master(is_master), .bus_busy(bus_busy), .si(si)
   );

   always @(posedge clk) begin
      tcnt <= tcnt + 1;
      half_tick <= ((tcnt % 4) == 3);
   end

   // behavioural reference model
   int ph = 0, nph, cnt;
   bit m_busy, m_master, m_si, m_bytes, m_first, ps = 1, pc = 1;
   bit n_master, n_bytes, n_first, set_si, ent2, so, co, sl, cl, st, sp;
   bit [4:0] m_ctl;
   function automatic bit exp_sda(int p); return p == 2 || p == 3 || p == 4; endfunction
   function automatic bit exp_scl(int p); return p == 3 || p == 6; endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; cnt = 0; m_busy = 0; m_master = 0; m_si = 0; m_bytes = 0;
         m_first = 0; m_ctl = 0; ps = 1; pc = 1;
      end else begin
         so = exp_sda(ph); co = exp_scl(ph);
         sl = !(so || ext_sda); cl = !(co || ext_scl);
         st = ps && !sl && cl && pc; sp = !ps && sl && cl && pc;
         ps = sl; pc = cl;
         nph = ph; n_master = m_master; n_first = m_first; set_si = 0; ent2 = 0;
         if (!m_ctl[0]) begin nph = 0; n_master = 0; end
         else case (ph)
            0: if (m_ctl[1] && !slv_addr && !m_busy) begin
                  nph = 1; cnt = (m_first && m_ctl[3]) ? 20 : 3;
               end
            1: if (m_busy || slv_addr || !m_ctl[1]) nph = 0;
               else if (half_tick) begin
                  if (cnt == 1) begin nph = 2; n_first = 0; ent2 = 1; end
                  else cnt--;
               end
            2: if (half_tick) begin nph = 3; n_master = 1; set_si = 1; end
            3: if (half_tick) begin
                  if (m_ctl[2]) nph = 4;
                  else if (m_ctl[1] && m_bytes) nph = 6;
               end
            4: if (half_tick) nph = 5;
            5: if (sp) begin nph = 0; n_master = 0; set_si = 1; end
            6: if (half_tick) nph = 7;
            default: if (half_tick) begin nph = 2; ent2 = 1; end
         endcase
         if (!m_ctl[0] || ent2) n_bytes = 0;
         else if (byte_done && m_master) n_bytes = 1;
         else n_bytes = m_bytes;
         if (set_si) m_si = 1; else if (si_clr) m_si = 0;
         if (!m_ctl[0]) m_busy = 0; else if (st) m_busy = 1; else if (sp) m_busy = 0;
         if (ctl_wr && ctl_wdata[0] && !m_ctl[0]) n_first = 1;
         if (ctl_wr) m_ctl = ctl_wdata; else if (sp) m_ctl[2] = 0;
         ph = nph; m_master = n_master; m_bytes = n_bytes; m_first = n_first;
      end
   end

   always @(negedge clk) if (rst_n && !done) begin
      checks++;
      if ({sda_oe, scl_oe, is_master, bus_busy, si, ctl_q} !==
          {exp_sda(ph), exp_scl(ph), m_master, m_busy, m_si, m_ctl}) begin
         errors++;
         $display("FAIL %s model compare: actual %b expected %b", cur_req,
            {sda_oe, scl_oe, is_master, bus_busy, si, ctl_q},
            {exp_sda(ph), exp_scl(ph), m_master, m_busy, m_si, m_ctl});
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] d);
      @(negedge clk); ctl_wr = 1; ctl_wdata = d;
      @(negedge clk); ctl_wr = 0;
   endtask

   task automatic measure(input logic [4:0] d, output int n);
      do @(negedge clk); while (!half_tick);
      ctl_wr = 1; ctl_wdata = d; n = 0;
      for (int g = 0; g < 400; g++) begin
         if (half_tick) n++;
         @(negedge clk); ctl_wr = 0;
         if (sda_oe) break;
      end
   endtask

   task automatic wait_master(input bit v);
      for (int g = 0; g < 300 && is_master != v; g++) @(negedge clk);
   endtask

   initial begin
      int n;
      bit seen;
      repeat (3) @(negedge clk);
      chk(!sda_oe && !scl_oe && !is_master && !bus_busy, "R1", "reset outputs", sda_oe, 0);
      rst_n = 1;
      @(negedge clk);
      chk(ctl_q == 0, "R1", "reset control word", ctl_q, 0);

      cur_req = "R3";
      measure(5'b01011, n);
      chk(n == 21, "R3", "long first start half-ticks (+1 write edge)", n, 21);
      chk(scl_oe == 0, "R2", "scl not yet low", scl_oe, 0);
      repeat (4) @(negedge clk);
      chk(scl_oe == 1, "R2", "scl low one half-tick later", scl_oe, 1);
      chk(is_master && si, "R10", "master and si after start", si, 1);
      @(negedge clk); si_clr = 1; @(negedge clk); si_clr = 0;
      chk(si == 0, "R10", "si cleared", si, 0);

      cur_req = "R7";
      wr(5'b01101);
      wait_master(0);
      @(negedge clk);
      chk(ctl_q[2] == 0 && !bus_busy, "R7", "stop bit cleared, bus free", ctl_q[2], 0);
      chk(si == 1, "R10", "si after stop", si, 1);

      cur_req = "R2";
      measure(5'b01011, n);
      chk(n == 4, "R2", "short start half-ticks (+1 write edge)", n, 4);
      wait_master(1);

      cur_req = "R6";
      @(negedge clk); byte_done = 1; @(negedge clk); byte_done = 0;
      for (int g = 0; g < 40 && sda_oe; g++) @(negedge clk);
      chk(!sda_oe, "R6", "sda released for repeated start", sda_oe, 0);
      for (int g = 0; g < 40 && !sda_oe; g++) @(negedge clk);
      chk(sda_oe && is_master, "R6", "repeated start driven as master", is_master, 1);
      chk(ctl_q[1] == 1, "R9", "start bit kept by hardware", ctl_q[1], 1);

      cur_req = "R8";
      wr(5'b00111);
      wait_master(0);
      chk(!is_master, "R8", "stop first", is_master, 0);
      wait_master(1);
      chk(is_master && ctl_q[2] == 0, "R8", "start after stop", is_master, 1);
      wr(5'b00101);
      wait_master(0);
      repeat (2) @(negedge clk);

      cur_req = "R4";
      ext_sda = 1; repeat (2) @(negedge clk);
      chk(bus_busy == 1, "R11", "foreign start seen", bus_busy, 1);
      wr(5'b00011);
      seen = 0;
      repeat (40) begin @(negedge clk); if (sda_oe) seen = 1; end
      chk(!seen, "R4", "no start while busy", seen, 0);
      ext_sda = 0; repeat (2) @(negedge clk);
      chk(bus_busy == 0, "R11", "foreign stop seen", bus_busy, 1'b0);
      wait_master(1);
      chk(is_master, "R4", "start after bus freed", is_master, 1);
      wr(5'b00101); wait_master(0); repeat (2) @(negedge clk);

      cur_req = "R5";
      slv_addr = 1; wr(5'b00011);
      seen = 0;
      repeat (40) begin @(negedge clk); if (sda_oe) seen = 1; end
      chk(!seen, "R5", "no start while addressed", seen, 0);
      slv_addr = 0; wait_master(1);
      chk(is_master, "R5", "start after slave phase", is_master, 1);

      cur_req = "R9";
      wr(5'b11001);
      chk(ctl_q == 5'b11001, "R9", "readback incl ack bit", ctl_q, 5'b11001);

      cur_req = "R1";
      wr(5'b00000); @(negedge clk);
      chk(!sda_oe && !scl_oe && !is_master && !bus_busy, "R1", "released on disable", is_master, 0);

      repeat (4) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1; errors++; checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule